// File: doc/BRIEF.md
# LIN UART status and break detector

This block keeps the status flags of a UART receiver and transmitter that can also run as a LIN node. It times how long the receive line stays low, in units of a bit-time tick from the baud generator, and raises a break flag once the low time reaches a threshold. The threshold depends on the node's LIN state: a short low wakes a sleeping node, a long low marks a break for a slave waiting for one, and a slightly shorter low marks a break in the middle of a frame.

Next to the break flag it holds the overrun, framing, autobaud-complete and transmit flags. Each flag has its own clear rule. Reads of the receive data register, reads of the status register and writes of the transmit data register arrive as single-cycle strobes, and each strobe clears the flags that belong to it. When a flag is set and cleared in the same cycle, the set wins. The block raises a receive interrupt while the autobaud-complete flag is set and its enable is on.

The low-time measurement is driven by a three-state machine:
- `BD_HIGH`: the line is high.
- `BD_LOW`: the line is low and being timed.
- `BD_DONE`: a break has fired and the machine waits for the line to go high.

Transitions:
- `BD_HIGH` to `BD_LOW` when RX is low.
- `BD_LOW` to `BD_DONE` when the low count reaches the threshold for the current state. This transition also sends a one-cycle break event to the flags.
- `BD_LOW` to `BD_HIGH` when RX returns high before the threshold.
- `BD_DONE` to `BD_HIGH` when RX is high.

Top module: `lin_uart_status`

## Requirements
- R1: In LIN sleep state (`lin_state` = 2'b01), a low of at least 4 bit ticks sets the break flag. A low of 3 ticks or fewer does not set it.
- R2: In wait-for-break state (`lin_state` = 2'b10), the break flag sets after at least 11 low ticks and not after 10 or fewer.
- R3: In active state (`lin_state` = 2'b11), the break flag sets after at least 10 low ticks and not after 9 or fewer.
- R4: With `lin_en` = 0, or with `lin_state` = 2'b00 (off), no low time sets the break flag.
- R5: The break flag sets at most once per low period. The low counter saturates, so a long low cannot wrap and fire again. The flag can set again only after RX has been high.
- R6: The break flag clears on a status read (`rd_status`) or on a receive-data read (`rd_rxdata`).
- R7: `rx_ovr_evt` sets the overrun flag (status bit 4). Only `rd_rxdata` clears it; `rd_status` leaves it set.
- R8: `rx_frm_evt` sets the framing flag (status bit 3). Only `rd_rxdata` clears it.
- R9: In LIN slave mode (`lin_en` = 1, `lin_master` = 0), `abd_ovf_evt` sets both the overrun flag and the autobaud flag (status bit 5).
- R10: In LIN slave mode, `abd_char_evt` sets the autobaud flag, and `rd_status` clears it. While `lin_master` = 1 the flag is held at 0 and autobaud events are ignored.
- R11: `rx_irq` is high while the autobaud flag is set and `abd_irq_en` = 1, and low otherwise.
- R12: Transmit flags:
  - The transmit-empty flag (bit 0) clears on `tx_hold_wr` and sets on `tx_hold_taken`.
  - The transmitter-idle flag (bit 1) is 1 only when that flag is 1 and `tx_shift_busy` = 0.
- R13: A set event and a clearing access in the same cycle leave the flag set.
- R14: Reset state:
  - Status bit layout: bit 0 transmit-empty, bit 1 transmitter-idle, bit 2 break, bit 3 framing, bit 4 overrun, bit 5 autobaud; bits 7:6 read 0.
  - After reset `status` = 8'h03, and `brk_flag` and `rx_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| rx_in | input | 1 | Receive line level |
| lin_en | input | 1 | LIN mode on |
| lin_master | input | 1 | 1 = LIN master, 0 = slave |
| lin_state | input | 2 | 00 off, 01 sleep, 10 wait-for-break, 11 active |
| abd_irq_en | input | 1 | Autobaud interrupt enable |
| rx_ovr_evt | input | 1 | Receive overrun event |
| rx_frm_evt | input | 1 | Missing stop bit event |
| abd_char_evt | input | 1 | Autobaud character received |
| abd_ovf_evt | input | 1 | Baud counter overflow during autobaud |
| tx_hold_wr | input | 1 | Write of transmit data register |
| tx_hold_taken | input | 1 | Transmit data moved to shift register |
| tx_shift_busy | input | 1 | Transmit shifter busy |
| rd_status | input | 1 | Status register read strobe |
| rd_rxdata | input | 1 | Receive data register read strobe |
| status | output | 8 | Status flags |
| brk_flag | output | 1 | Break flag (same as status bit 2) |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The break detector is swept over every LIN state with low periods from 1 to 13 ticks. This shows that each state uses its own threshold and that the boundary sits exactly between the threshold and one tick less. The same sweep with LIN off, or with the state set to off, shows that detection can be disabled. A held low of 20 ticks, with a read in the middle, separates one-shot firing from re-firing or counter wrap. Pulses of single events, each followed by reads of either register, tell the clear rule of each flag apart from the others. Coincident set and clear strobes then show which of the two wins.

// File: rtl/lin_stat_pkg.sv
package lin_stat_pkg;
    typedef enum logic [1:0] {
        LIN_OFF      = 2'b00,
        LIN_SLEEP    = 2'b01,
        LIN_WAIT_BRK = 2'b10,
        LIN_ACTIVE   = 2'b11
    } lin_state_e;

    typedef enum logic [1:0] {
        BD_HIGH = 2'b00,
        BD_LOW  = 2'b01,
        BD_DONE = 2'b10
    } brk_state_e;

    // internal flag slots
    localparam int F_TDRE = 0;
    localparam int F_BRK  = 1;
    localparam int F_FE   = 2;
    localparam int F_OE   = 3;
    localparam int F_ATB  = 4;
    localparam int NFLAGS = 5;
endpackage

// File: rtl/lin_low_timer.sv
module lin_low_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             rx_in,
    output logic [CNT_W-1:0] low_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (rx_in)
            low_cnt <= '0;
        else if (bit_tick && (low_cnt != CNT_MAX))
            low_cnt <= low_cnt + 1'b1;
    end
endmodule

// File: rtl/lin_break_fsm.sv
module lin_break_fsm
    import lin_stat_pkg::*;
#(
    parameter int SLEEP_BITS  = 4,
    parameter int WAIT_BITS   = 11,
    parameter int ACTIVE_BITS = 10,
    parameter int CNT_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_in,
    input  logic             lin_en,
    input  lin_state_e       lin_state,
    input  logic [CNT_W-1:0] low_cnt,
    output logic             brk_evt
);
    brk_state_e       st_q, st_d;
    logic [CNT_W-1:0] thr;
    logic             thr_ok;
    logic             reach;

    always_comb begin
        unique case (lin_state)
            LIN_SLEEP:    begin thr = CNT_W'(SLEEP_BITS);  thr_ok = lin_en; end
            LIN_WAIT_BRK: begin thr = CNT_W'(WAIT_BITS);   thr_ok = lin_en; end
            LIN_ACTIVE:   begin thr = CNT_W'(ACTIVE_BITS); thr_ok = lin_en; end
            default:      begin thr = '0;                  thr_ok = 1'b0;   end
        endcase
    end

    assign reach = thr_ok && (low_cnt >= thr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= BD_HIGH;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BD_HIGH: if (!rx_in) st_d = BD_LOW;
            BD_LOW: begin
                if (reach)      st_d = BD_DONE;
                else if (rx_in) st_d = BD_HIGH;
            end
            BD_DONE: if (rx_in) st_d = BD_HIGH;
            default: st_d = BD_HIGH;
        endcase
    end

    always_comb begin
        brk_evt = 1'b0;
        unique case (st_q)
            BD_LOW:  brk_evt = reach;
            default: brk_evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/lin_status_flags.sv
module lin_status_flags
    import lin_stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lin_en,
    input  logic              lin_master,
    input  logic              brk_evt,
    input  logic              rx_ovr_evt,
    input  logic              rx_frm_evt,
    input  logic              abd_char_evt,
    input  logic              abd_ovf_evt,
    input  logic              tx_hold_wr,
    input  logic              tx_hold_taken,
    input  logic              rd_status,
    input  logic              rd_rxdata,
    output logic [NFLAGS-1:0] flags
);
    localparam logic [NFLAGS-1:0] RST_VAL = NFLAGS'(1) << F_TDRE;

    logic [NFLAGS-1:0] set_v, clr_v;
    logic              slave;

    assign slave = lin_en && !lin_master;

    always_comb begin
        set_v         = '0;
        clr_v         = '0;
        set_v[F_TDRE] = tx_hold_taken;
        clr_v[F_TDRE] = tx_hold_wr;
        set_v[F_BRK]  = brk_evt;
        clr_v[F_BRK]  = rd_status || rd_rxdata;
        set_v[F_FE]   = rx_frm_evt;
        clr_v[F_FE]   = rd_rxdata;
        set_v[F_OE]   = rx_ovr_evt || (slave && abd_ovf_evt);
        clr_v[F_OE]   = rd_rxdata;
        set_v[F_ATB]  = slave && (abd_char_evt || abd_ovf_evt);
        clr_v[F_ATB]  = rd_status || lin_master;
    end

    for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flags[i] <= RST_VAL[i];
            else if (set_v[i]) flags[i] <= 1'b1;
            else if (clr_v[i]) flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/lin_uart_status.sv
module lin_uart_status
    import lin_stat_pkg::*;
#(
    parameter int SLEEP_BITS  = 4,
    parameter int WAIT_BITS   = 11,
    parameter int ACTIVE_BITS = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic       rx_in,
    input  logic       lin_en,
    input  logic       lin_master,
    input  logic [1:0] lin_state,
    input  logic       abd_irq_en,
    input  logic       rx_ovr_evt,
    input  logic       rx_frm_evt,
    input  logic       abd_char_evt,
    input  logic       abd_ovf_evt,
    input  logic       tx_hold_wr,
    input  logic       tx_hold_taken,
    input  logic       tx_shift_busy,
    input  logic       rd_status,
    input  logic       rd_rxdata,
    output logic [7:0] status,
    output logic       brk_flag,
    output logic       rx_irq
);
    localparam int MAX_A  = (SLEEP_BITS > WAIT_BITS) ? SLEEP_BITS : WAIT_BITS;
    localparam int MAX_TH = (MAX_A > ACTIVE_BITS) ? MAX_A : ACTIVE_BITS;
    localparam int CNT_W  = $clog2(MAX_TH + 1);

    logic [CNT_W-1:0]  low_cnt;
    logic              brk_evt;
    logic [NFLAGS-1:0] flags;

    lin_low_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .rx_in    (rx_in),
        .low_cnt  (low_cnt)
    );

    lin_break_fsm #(
        .SLEEP_BITS  (SLEEP_BITS),
        .WAIT_BITS   (WAIT_BITS),
        .ACTIVE_BITS (ACTIVE_BITS),
        .CNT_W       (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_in     (rx_in),
        .lin_en    (lin_en),
        .lin_state (lin_state_e'(lin_state)),
        .low_cnt   (low_cnt),
        .brk_evt   (brk_evt)
    );

    lin_status_flags u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .lin_en        (lin_en),
        .lin_master    (lin_master),
        .brk_evt       (brk_evt),
        .rx_ovr_evt    (rx_ovr_evt),
        .rx_frm_evt    (rx_frm_evt),
        .abd_char_evt  (abd_char_evt),
        .abd_ovf_evt   (abd_ovf_evt),
        .tx_hold_wr    (tx_hold_wr),
        .tx_hold_taken (tx_hold_taken),
        .rd_status     (rd_status),
        .rd_rxdata     (rd_rxdata),
        .flags         (flags)
    );

    assign status   = {2'b00, flags[F_ATB], flags[F_OE], flags[F_FE], flags[F_BRK],
                       (flags[F_TDRE] && !tx_shift_busy), flags[F_TDRE]};
    assign brk_flag = flags[F_BRK];
    assign rx_irq   = flags[F_ATB] && abd_irq_en;
endmodule

// File: rtl/lin_uart_status_chk.sv
module lin_uart_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lin_en,
    input logic       lin_master,
    input logic [1:0] lin_state,
    input logic       rx_frm_evt,
    input logic       tx_hold_wr,
    input logic       tx_hold_taken,
    input logic       rd_rxdata,
    input logic [7:0] status,
    input logic       brk_flag
);
    AST_BRK_NEEDS_LIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_flag) |-> ($past(lin_en) && ($past(lin_state) != 2'b00))); // R4
    AST_OE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (status[4] && !rd_rxdata) |=> status[4]); // R7
    AST_FE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3] && !rd_rxdata) |=> status[3]); // R8
    AST_ATB_MASTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lin_master |=> !status[5]); // R10
    AST_TDRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_hold_wr && !tx_hold_taken) |=> !status[0]); // R12
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frm_evt |=> status[3]); // R13
endmodule

bind lin_uart_status lin_uart_status_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lin_en        (lin_en),
    .lin_master    (lin_master),
    .lin_state     (lin_state),
    .rx_frm_evt    (rx_frm_evt),
    .tx_hold_wr    (tx_hold_wr),
    .tx_hold_taken (tx_hold_taken),
    .rd_rxdata     (rd_rxdata),
    .status        (status),
    .brk_flag      (brk_flag)
);

// File: tb/lin_uart_status_bench.sv
module lin_uart_status_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 0, rx_in = 1, lin_en = 0, lin_master = 0;
    logic [1:0] lin_state = 2'b00;
    logic       abd_irq_en = 0, rx_ovr_evt = 0, rx_frm_evt = 0;
    logic       abd_char_evt = 0, abd_ovf_evt = 0;
    logic       tx_hold_wr = 0, tx_hold_taken = 0, tx_shift_busy = 0;
    logic       rd_status = 0, rd_rxdata = 0;
    logic [7:0] status;
    logic       brk_flag, rx_irq;

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;

    lin_uart_status u_lin_uart_status (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_in(rx_in),
        .lin_en(lin_en), .lin_master(lin_master), .lin_state(lin_state),
        .abd_irq_en(abd_irq_en), .rx_ovr_evt(rx_ovr_evt), .rx_frm_evt(rx_frm_evt),
        .abd_char_evt(abd_char_evt), .abd_ovf_evt(abd_ovf_evt),
        .tx_hold_wr(tx_hold_wr), .tx_hold_taken(tx_hold_taken),
        .tx_shift_busy(tx_shift_busy), .rd_status(rd_status), .rd_rxdata(rd_rxdata),
        .status(status), .brk_flag(brk_flag), .rx_irq(rx_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) bit_tick = 1'b1;
            @(negedge clk) bit_tick = 1'b0;
            cyc(2);
        end
    endtask

    task automatic pulse_rd_status();
        @(negedge clk) rd_status = 1'b1;
        @(negedge clk) rd_status = 1'b0;
    endtask

    task automatic pulse_rd_rxdata();
        @(negedge clk) rd_rxdata = 1'b1;
        @(negedge clk) rd_rxdata = 1'b0;
    endtask

    function automatic int thr_of(input int s);
        return (s == 1) ? 4 : (s == 2) ? 11 : 10;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        chk("R14 reset status", status, 8'h03);
        chk("R14 reset brk", brk_flag, 0);
        chk("R14 reset irq", rx_irq, 0);

        // R1 R2 R3: threshold sweep per state
        lin_en = 1'b1;
        for (int s = 1; s < 4; s++) begin
            lin_state = 2'(s);
            for (int len = 1; len <= 13; len++) begin
                @(negedge clk) rx_in = 1'b0;
                ticks(len);
                cyc(2);
                chk((s == 1) ? "R1 sleep threshold" : (s == 2) ? "R2 wait threshold" : "R3 active threshold",
                    brk_flag, (len >= thr_of(s)) ? 1 : 0);
                @(negedge clk) rx_in = 1'b1;
                cyc(2);
                if (s == 3) pulse_rd_rxdata(); else pulse_rd_status();
                cyc(1);
                chk("R6 break cleared by read", brk_flag, 0);
            end
        end

        // R4: LIN off or state off
        for (int m = 0; m < 2; m++) begin
            lin_en    = (m == 0) ? 1'b0 : 1'b1;
            lin_state = (m == 0) ? 2'b11 : 2'b00;
            @(negedge clk) rx_in = 1'b0;
            ticks(13);
            cyc(2);
            chk("R4 no break when disabled", brk_flag, 0);
            @(negedge clk) rx_in = 1'b1;
            cyc(2);
        end

        // R5: one fire per low, saturating counter
        lin_en = 1'b1;
        lin_state = 2'b11;
        @(negedge clk) rx_in = 1'b0;
        ticks(10);
        cyc(2);
        chk("R5 first fire", brk_flag, 1);
        pulse_rd_status();
        ticks(20);
        cyc(2);
        chk("R5 no refire while low", brk_flag, 0);
        @(negedge clk) rx_in = 1'b1;
        cyc(2);
        @(negedge clk) rx_in = 1'b0;
        ticks(10);
        cyc(2);
        chk("R5 refire after high", brk_flag, 1);
        @(negedge clk) rx_in = 1'b1;
        pulse_rd_rxdata();
        cyc(1);

        // R7 overrun
        @(negedge clk) rx_ovr_evt = 1'b1;
        @(negedge clk) rx_ovr_evt = 1'b0;
        chk("R7 overrun set", status[4], 1);
        pulse_rd_status();
        chk("R7 overrun kept on status read", status[4], 1);
        pulse_rd_rxdata();
        chk("R7 overrun cleared on data read", status[4], 0);

        // R8 framing
        @(negedge clk) rx_frm_evt = 1'b1;
        @(negedge clk) rx_frm_evt = 1'b0;
        chk("R8 framing set", status[3], 1);
        pulse_rd_status();
        chk("R8 framing kept on status read", status[3], 1);
        pulse_rd_rxdata();
        chk("R8 framing cleared on data read", status[3], 0);

        // R9 autobaud overflow in slave
        lin_master = 1'b0;
        @(negedge clk) abd_ovf_evt = 1'b1;
        @(negedge clk) abd_ovf_evt = 1'b0;
        chk("R9 ovf sets overrun and autobaud", status[5:4], 2'b11);
        pulse_rd_rxdata();
        chk("R9 data read leaves autobaud", status[5:4], 2'b10);
        pulse_rd_status();
        chk("R10 status read clears autobaud", status[5], 0);

        // R10 / R11 autobaud char and irq
        abd_irq_en = 1'b1;
        @(negedge clk) abd_char_evt = 1'b1;
        @(negedge clk) abd_char_evt = 1'b0;
        chk("R10 autobaud set in slave", status[5], 1);
        chk("R11 irq with enable", rx_irq, 1);
        abd_irq_en = 1'b0;
        cyc(1);
        chk("R11 irq masked", rx_irq, 0);
        lin_master = 1'b1;
        cyc(1);
        chk("R10 autobaud zero in master", status[5], 0);
        @(negedge clk) abd_char_evt = 1'b1;
        @(negedge clk) abd_char_evt = 1'b0;
        chk("R10 master ignores autobaud char", status[5], 0);
        lin_master = 1'b0;

        // R12 transmit flags
        @(negedge clk) tx_hold_wr = 1'b1;
        @(negedge clk) tx_hold_wr = 1'b0;
        chk("R12 write clears empty flags", status[1:0], 2'b00);
        tx_shift_busy = 1'b1;
        @(negedge clk) tx_hold_taken = 1'b1;
        @(negedge clk) tx_hold_taken = 1'b0;
        chk("R12 handoff sets empty, shifter busy", status[1:0], 2'b01);
        tx_shift_busy = 1'b0;
        cyc(1);
        chk("R12 idle when shifter done", status[1:0], 2'b11);

        // R13 set wins
        @(negedge clk) begin rx_frm_evt = 1'b1; rd_rxdata = 1'b1; end
        @(negedge clk) begin rx_frm_evt = 1'b0; rd_rxdata = 1'b0; end
        chk("R13 framing set beats read", status[3], 1);
        @(negedge clk) begin tx_hold_wr = 1'b1; tx_hold_taken = 1'b1; end
        @(negedge clk) begin tx_hold_wr = 1'b0; tx_hold_taken = 1'b0; end
        chk("R13 handoff beats write", status[0], 1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule